// File: doc/BRIEF.md
# Queue Interrupt Condition Selector

This block turns the status flags of 64 hardware queues into two interrupt lines. The lower half (queues 0 to 31) and the upper half (queues 32 to 63) each get their own line, their own 32-bit enable register and their own 32-bit pending register. Each lower queue supplies four status flags and has a small source field. The field picks one of the four flags and can invert it, and the result is that queue's interrupt condition. Each upper queue supplies only a nearly-empty flag, and its condition is always that flag being low (the queue is not nearly empty).

A queue whose condition is true while its enable bit is set marks its pending bit. The pending bit stays set until software writes a one to it. Each interrupt line is high while any pending bit of its half is set. The block has a flat register space: a write port, and a read port that returns data combinationally from the current register state. Status flags come in from the queue logic as plain inputs.

Top module: `qis_irq_sel`

## Requirements
- R1: After reset every source field, enable bit and pending bit reads zero, and both interrupt lines are low.
- R2: Source registers sit at addresses 0 to 3. Queue q owns bits [4*(q%8)+2 : 4*(q%8)] of register q/8. Bit 4*(q%8)+3 is reserved: writes to it are ignored and it reads zero.
- R3: A lower queue's condition is lo_flags_i[4*q + s[1:0]] XOR s[2], where s is its source field.
- R4: Upper queue 32+j has a fixed condition, true when hi_nearly_empty_i[j] is 0.
- R5: On any clock edge where a queue's condition is true and its enable bit is set, its pending bit reads one after that edge. It stays one after the condition drops, until it is cleared.
- R6: A queue whose enable bit is zero never sets its pending bit, whatever its condition is.
- R7: Pending registers sit at address 6 (lower) and 7 (upper). A write clears exactly the bits written as one and leaves the others unchanged. Writing all ones clears the whole half.
- R8: When a clear and a set hit the same pending bit in the same cycle, the bit ends up set.
- R9: irq_lo_o is the OR of the lower pending bits and irq_hi_o is the OR of the upper pending bits. Bit q%32 of each half register belongs to queue q.
- R10: Enable registers sit at address 4 (lower) and 5 (upper). They are written directly, read back, and take effect from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lo_flags_i | input | 128 | Four status flags per lower queue; flag k of queue q at bit 4*q+k |
| hi_nearly_empty_i | input | 32 | Nearly-empty flag of upper queue 32+j at bit j |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Register read data, combinational |
| irq_lo_o | output | 1 | Interrupt line for queues 0 to 31 |
| irq_hi_o | output | 1 | Interrupt line for queues 32 to 63 |

## Verification
The hardest case to reach is a write-one-to-clear that lands on the very cycle when the same queue's enabled condition is true. Only then does the rule that a set beats a clear show up. Directed sequences hold an upper queue's nearly-empty flag low while issuing an all-ones clear, so the collision happens. The random phase keeps flags toggling under frequent clear writes to reach the same situation on the lower half. A directed sweep walks one lower queue through all eight source codes against a fixed flag pattern, so that every flag selection is tested both plain and inverted.

// File: rtl/qis_pkg.sv
package qis_pkg;
  localparam int unsigned FLAG_N = 4;  // status flags per lower queue
  localparam int unsigned SEL_W  = $clog2(FLAG_N);
  localparam int unsigned SRC_W  = SEL_W + 1;  // select + invert
  localparam int unsigned SLOT_W = 4;  // field slot incl. reserved bit
  localparam int unsigned N_HALF = 2;
  typedef logic [SRC_W-1:0] src_t;
endpackage

// File: rtl/qis_cond_sel.sv
module qis_cond_sel
  import qis_pkg::*;
(
  input  logic [FLAG_N-1:0] flags_i,
  input  src_t              src_i,
  output logic              hit_o
);
  logic picked;
  assign picked = flags_i[src_i[SEL_W-1:0]];
  assign hit_o  = picked ^ src_i[SEL_W];
endmodule

// File: rtl/qis_src_bank.sv
module qis_src_bank
  import qis_pkg::*;
#(
  parameter int unsigned HALF_Q = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned PER_REG = DATA_W / SLOT_W,
  localparam int unsigned NREG    = HALF_Q / PER_REG,
  localparam int unsigned IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [IDX_W-1:0]         rd_idx_i,
  output logic [HALF_Q*SRC_W-1:0]  src_o,
  output logic [DATA_W-1:0]        rd_data_o
);
  src_t src_q [HALF_Q];

  for (genvar q = 0; q < HALF_Q; q++) begin : g_field
    localparam int unsigned R = q / PER_REG;
    localparam int unsigned S = q % PER_REG;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_q[q] <= '0;
      end else if (wr_i && (wr_idx_i == IDX_W'(R))) begin
        src_q[q] <= wr_data_i[S*SLOT_W +: SRC_W];
      end
    end
    assign src_o[q*SRC_W +: SRC_W] = src_q[q];
  end

  // reserved slot bits read as zero
  always_comb begin
    rd_data_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_idx_i == IDX_W'(r)) begin
        for (int s = 0; s < PER_REG; s++) begin
          rd_data_o[s*SLOT_W +: SRC_W] = src_q[r*PER_REG + s];
        end
      end
    end
  end
endmodule

// File: rtl/qis_pend_bank.sv
module qis_pend_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_wr_i,
  input  logic [W-1:0] en_data_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] cond_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] req_o,
  output logic         irq_o
);
  logic [W-1:0] en_q, pend_q;

  assign req_o = cond_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr_i) en_q <= en_data_i;
      // a new request outranks a clear in the same cycle
      pend_q <= (pend_q & ~clr_mask_i) | req_o;
    end
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/qis_irq_sel.sv
module qis_irq_sel
  import qis_pkg::*;
#(
  parameter int unsigned HALF_Q = 32,
  localparam int unsigned DATA_W  = HALF_Q,
  localparam int unsigned PER_REG = DATA_W / SLOT_W,
  localparam int unsigned NSRC    = HALF_Q / PER_REG,
  localparam int unsigned A_EN    = NSRC,
  localparam int unsigned A_PEND  = NSRC + N_HALF,
  localparam int unsigned ADDR_W  = $clog2(NSRC + 2 * N_HALF),
  localparam int unsigned IDX_W   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [HALF_Q*FLAG_N-1:0] lo_flags_i,
  input  logic [HALF_Q-1:0]        hi_nearly_empty_i,
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     irq_lo_o,
  output logic                     irq_hi_o
);
  logic [HALF_Q*SRC_W-1:0] src_flat;
  logic [DATA_W-1:0]       src_rd;
  logic                    src_wr;
  logic [HALF_Q-1:0]       cond [N_HALF];
  logic [HALF_Q-1:0]       en   [N_HALF];
  logic [HALF_Q-1:0]       pend [N_HALF];
  logic [HALF_Q-1:0]       req  [N_HALF];
  logic [HALF_Q-1:0]       clr  [N_HALF];
  logic                    en_wr [N_HALF];
  logic                    irq  [N_HALF];

  assign src_wr = wr_en_i && (wr_addr_i < ADDR_W'(NSRC));

  qis_src_bank #(
    .HALF_Q (HALF_Q),
    .DATA_W (DATA_W)
  ) i_src (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (src_wr),
    .wr_idx_i  (wr_addr_i[IDX_W-1:0]),
    .wr_data_i (wr_data_i),
    .rd_idx_i  (rd_addr_i[IDX_W-1:0]),
    .src_o     (src_flat),
    .rd_data_o (src_rd)
  );

  // lower half: selectable condition
  for (genvar q = 0; q < HALF_Q; q++) begin : g_lo
    qis_cond_sel i_sel (
      .flags_i (lo_flags_i[q*FLAG_N +: FLAG_N]),
      .src_i   (src_flat[q*SRC_W +: SRC_W]),
      .hit_o   (cond[0][q])
    );
  end

  // upper half: fixed not-nearly-empty condition
  assign cond[1] = ~hi_nearly_empty_i;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    assign en_wr[h] = wr_en_i && (wr_addr_i == ADDR_W'(A_EN + h));
    assign clr[h]   = (wr_en_i && (wr_addr_i == ADDR_W'(A_PEND + h))) ? wr_data_i : '0;

    qis_pend_bank #(
      .W (HALF_Q)
    ) i_pend (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_wr_i    (en_wr[h]),
      .en_data_i  (wr_data_i),
      .clr_mask_i (clr[h]),
      .cond_i     (cond[h]),
      .en_o       (en[h]),
      .pend_o     (pend[h]),
      .req_o      (req[h]),
      .irq_o      (irq[h])
    );
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(NSRC)) rd_data_o = src_rd;
    for (int h = 0; h < N_HALF; h++) begin
      if (rd_addr_i == ADDR_W'(A_EN + h))   rd_data_o = en[h];
      if (rd_addr_i == ADDR_W'(A_PEND + h)) rd_data_o = pend[h];
    end
  end

  assign irq_lo_o = irq[0];
  assign irq_hi_o = irq[1];

  // flat views for the bound checker
  logic [HALF_Q-1:0] req_lo, req_hi, en_lo, en_hi, clr_lo, clr_hi;
  assign req_lo = req[0];
  assign req_hi = req[1];
  assign en_lo  = en[0];
  assign en_hi  = en[1];
  assign clr_lo = clr[0];
  assign clr_hi = clr[1];
endmodule

// File: rtl/qis_irq_sel_chk.sv
module qis_irq_sel_chk #(
  parameter int unsigned HALF_Q = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_lo_o,
  input logic              irq_hi_o,
  input logic [HALF_Q-1:0] hi_nearly_empty_i,
  input logic [HALF_Q-1:0] req_lo,
  input logic [HALF_Q-1:0] req_hi,
  input logic [HALF_Q-1:0] en_lo,
  input logic [HALF_Q-1:0] en_hi,
  input logic [HALF_Q-1:0] clr_lo,
  input logic [HALF_Q-1:0] clr_hi
);
  assert_set_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_lo) |=> irq_lo_o);

  assert_sticky_lo_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_lo_o && clr_lo == '0) |=> irq_lo_o);

  assert_sticky_hi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_hi_o && clr_hi == '0) |=> irq_hi_o);

  assert_hi_cond_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(en_hi & ~hi_nearly_empty_i)) |=> irq_hi_o);

  assert_disabled_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_lo == '0 && !irq_lo_o) |=> !irq_lo_o);

  assert_disabled_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_hi == '0 && !irq_hi_o) |=> !irq_hi_o);

  assert_clear_all_lo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&clr_lo) && req_lo == '0) |=> !irq_lo_o);

  assert_set_wins_hi_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_hi & req_hi)) |=> irq_hi_o);
endmodule

bind qis_irq_sel qis_irq_sel_chk #(.HALF_Q(HALF_Q)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .irq_lo_o          (irq_lo_o),
  .irq_hi_o          (irq_hi_o),
  .hi_nearly_empty_i (hi_nearly_empty_i),
  .req_lo            (req_lo),
  .req_hi            (req_hi),
  .en_lo             (en_lo),
  .en_hi             (en_hi),
  .clr_lo            (clr_lo),
  .clr_hi            (clr_hi)
);

// File: tb/test_qis_irq_sel.sv
module test_qis_irq_sel;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] lo_flags = '0;
  logic [31:0]  hi_ne = '1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [31:0]  rd_data;
  logic         irq_lo, irq_hi;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [2:0]  m_src [32];
  logic [31:0] m_en  [2];
  logic [31:0] m_pend[2];

  always #5 clk = ~clk;

  qis_irq_sel i_qis_irq_sel (
    .clk_i             (clk),
    .rst_ni            (rst_n),
    .lo_flags_i        (lo_flags),
    .hi_nearly_empty_i (hi_ne),
    .wr_en_i           (wr_en),
    .wr_addr_i         (wr_addr),
    .wr_data_i         (wr_data),
    .rd_addr_i         (rd_addr),
    .rd_data_o         (rd_data),
    .irq_lo_o          (irq_lo),
    .irq_hi_o          (irq_hi)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] cond_lo();
    logic [31:0] c;
    for (int q = 0; q < 32; q++)
      c[q] = lo_flags[4*q + int'(m_src[q][1:0])] ^ m_src[q][2];
    return c;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    logic [31:0] v = '0;
    if (a < 3'd4) begin
      for (int s = 0; s < 8; s++) v[4*s +: 3] = m_src[int'(a)*8 + s];
    end else if (a < 3'd6) v = m_en[a - 3'd4];
    else v = m_pend[a - 3'd6];
    return v;
  endfunction

  task automatic tick();
    logic [31:0] c0, c1, np0, np1, k0, k1;
    c0 = cond_lo();
    c1 = ~hi_ne;
    k0 = (wr_en && wr_addr == 3'd6) ? wr_data : '0;
    k1 = (wr_en && wr_addr == 3'd7) ? wr_data : '0;
    np0 = (m_pend[0] & ~k0) | (c0 & m_en[0]);
    np1 = (m_pend[1] & ~k1) | (c1 & m_en[1]);
    @(posedge clk);
    m_pend[0] = np0;
    m_pend[1] = np1;
    if (wr_en) begin
      if (wr_addr < 3'd4)
        for (int s = 0; s < 8; s++) m_src[int'(wr_addr)*8 + s] = wr_data[4*s +: 3];
      else if (wr_addr == 3'd4) m_en[0] = wr_data;
      else if (wr_addr == 3'd5) m_en[1] = wr_data;
    end
    #1;
    chk("R9 irq_lo", {31'd0, irq_lo}, {31'd0, |m_pend[0]});
    chk("R9 irq_hi", {31'd0, irq_hi}, {31'd0, |m_pend[1]});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp_rd(a));
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #5_000_000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int q = 0; q < 32; q++) m_src[q] = '0;
    m_en[0] = '0; m_en[1] = '0; m_pend[0] = '0; m_pend[1] = '0;
    #23;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd_addr = 3'(a); #1;
      chk("R1 reset reg", rd_data, 32'd0);
    end
    chk("R1 reset irq", {30'd0, irq_lo, irq_hi}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: source layout, reserved bits read zero
    for (int a = 0; a < 4; a++) begin
      logic [31:0] d = $urandom();
      wr(3'(a), d);
      rd_addr = 3'(a); #1;
      chk("R2 src readback", rd_data, d & 32'h7777_7777);
    end
    // R10: enable readback (flags off, hi not empty-free)
    wr(3'd4, 32'h0000_0000);
    wr(3'd5, 32'hA5A5_0F0F);
    rd_chk("R10 en_hi readback", 3'd5);
    wr(3'd5, 32'd0);
    wr(3'd7, '1);
    wr(3'd6, '1);

    // R3: queue 5 through all source codes, flags pattern 0110
    lo_flags = '0;
    lo_flags[5*4 +: 4] = 4'b0110;
    for (int s = 0; s < 8; s++) begin
      logic expb;
      wr(3'd4, 32'd0);
      wr(3'd0, 32'(s) << 20);
      wr(3'd6, '1);
      wr(3'd4, 32'h20);
      tick();
      expb = 4'b0110 >> (s % 4);
      expb = expb ^ (s >= 4);
      rd_addr = 3'd6; #1;
      chk("R3 sel/invert", rd_data, {26'd0, expb, 5'd0});
    end
    wr(3'd4, 32'd0);
    wr(3'd6, '1);
    lo_flags = '0;

    // R4: upper fixed condition
    wr(3'd5, 32'h88);
    hi_ne = '1;
    tick();
    rd_addr = 3'd7; #1;
    chk("R4 ne high no req", rd_data, 32'd0);
    hi_ne[3] = 1'b0;
    tick();
    rd_addr = 3'd7; #1;
    chk("R4 ne low sets", rd_data, 32'h08);
    chk("R9 irq_hi on", {31'd0, irq_hi}, 32'd1);
    // R5: sticky after condition drops
    hi_ne = '1;
    tick(); tick();
    rd_addr = 3'd7; #1;
    chk("R5 sticky", rd_data, 32'h08);
    // R7: partial clears
    hi_ne[7] = 1'b0; tick(); hi_ne = '1;
    wr(3'd7, 32'h08);
    rd_addr = 3'd7; #1;
    chk("R7 clear one bit", rd_data, 32'h80);
    wr(3'd7, 32'h00);
    rd_addr = 3'd7; #1;
    chk("R7 zero write no effect", rd_data, 32'h80);
    wr(3'd7, '1);
    rd_addr = 3'd7; #1;
    chk("R7 clear all", rd_data, 32'h00);
    chk("R7 irq_hi off", {31'd0, irq_hi}, 32'd0);
    // R8: set beats clear
    hi_ne[3] = 1'b0;
    wr(3'd7, '1);
    rd_addr = 3'd7; #1;
    chk("R8 set wins", rd_data, 32'h08);
    // R6: disabled queues never set
    wr(3'd5, 32'd0);
    wr(3'd7, '1);
    hi_ne = '0;
    lo_flags = '1;
    for (int q = 0; q < 32; q++) m_src[q] = m_src[q];
    wr(3'd4, 32'd0);
    wr(3'd6, '1);
    tick(); tick(); tick();
    rd_addr = 3'd6; #1;
    chk("R6 lo disabled", rd_data, 32'd0);
    rd_addr = 3'd7; #1;
    chk("R6 hi disabled", rd_data, 32'd0);
    chk("R6 irq lines", {30'd0, irq_lo, irq_hi}, 32'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] a;
      lo_flags = {$urandom(), $urandom(), $urandom(), $urandom()};
      hi_ne = $urandom() | $urandom();
      wr_en = ($urandom() % 3) == 0;
      wr_addr = 3'($urandom());
      wr_data = ($urandom() % 4 == 0) ? '1 : $urandom();
      tick();
      wr_en = 1'b0;
      a = 3'($urandom());
      if (a < 3'd4) rd_chk("R2 random src", a);
      else if (a < 3'd6) rd_chk("R10 random en", a);
      else rd_chk("R5 random pend", a);
    end

    done = 1'b1;
    finish_run();
  end
endmodule